// File: doc/BRIEF.md
# Fuse-Mapped Programmable AND Plane

This block is the sum-of-products core of a small programmable logic cell. It keeps a flat configuration map in flip-flops. The map is filled one bit per clock through a serial port. From that map the block evaluates 64 product terms at once, combinationally, over 32 array literals. The literals are the true and inverted forms of 16 selected signals. The signals are pins or feedback, chosen outside the block.

The same map carries the architecture controls that the output cells use downstream. These are a polarity bit and an I/O-select bit for each cell, one disable bit for each term, and two global mode bits. The map also carries a 64-bit user signature, which the block stores and presents unchanged. The eight output cells each own a group of eight consecutive terms. The first term of cell c starts at fuse address 256·c.

Top module: `fuse_and_array`

## Requirements
- R1: After reset `done_o` is 0, `term_o` is all zero, and every stored fuse is 0.
- R2: Each clock with `load_i` high shifts `fuse_bit_i` into the map. The first bit of a load lands at address 0. `done_o` is still 0 after 2193 strobes and becomes 1 on the clock of the 2194th strobe.
- R3: While `done_o` is 0 (before the first complete load, or while a load is in progress), every bit of `term_o` is 0.
- R4: Term t uses fuses at addresses 32·t to 32·t+31. Fuse 32·t+2k connects `sig_i[k]` and fuse 32·t+2k+1 connects its inverse. A fuse value of 1 means intact (connected). The term is the AND of its connected literals, so a term with every fuse at 0 reads 1.
- R5: A term whose 32 fuses are all 1 reads 0 for every input pattern.
- R6: When the disable bit at address 2128+t is 1, term t reads 0 whatever its fuses hold.
- R7: `xor_o[c]` is the bit at address 2048+c and `ac1_o[c]` is the bit at address 2120+c. `syn_o` is address 2192 and `ac0_o` is address 2193.
- R8: `ues_o[i]` is the bit at address 2056+i, for i from 0 to 63.
- R9: Clocks with `load_i` low leave the map, the bit count and `done_o` unchanged, whatever `fuse_bit_i` holds. Gaps inside a load do not disturb the result.
- R10: A strobe while `done_o` is 1 starts a new load. That bit goes to address 0, `done_o` drops on that clock, and the terms stay 0 until the new load completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Serial load strobe, one fuse per clock |
| fuse_bit_i | input | 1 | Serial fuse data |
| sig_i | input | 16 | Signals feeding the array literals |
| term_o | output | 64 | Product term values |
| done_o | output | 1 | Map completely loaded |
| xor_o | output | 8 | Per-cell polarity bits |
| ac1_o | output | 8 | Per-cell I/O select bits |
| ues_o | output | 64 | Stored user signature |
| syn_o | output | 1 | Global mode bit (first) |
| ac0_o | output | 1 | Global mode bit (second) |

## Verification
The serial load and the term evaluation meet in a single cycle when a strobe arrives while a complete map is live. The first strobe of a new load must drop `done_o` and silence every term on that same edge. The bench provokes this from a state where known terms read 1. It checks at the next falling edge that both the flag and the whole term vector are 0. It then checks that the terms return with the values of the second map only after its final strobe.

// File: rtl/fam_pkg.sv
`timescale 1ns/1ps
package fam_pkg;
  localparam int unsigned DEF_CELLS          = 8;
  localparam int unsigned DEF_TERMS_PER_CELL = 8;
  localparam int unsigned DEF_SIGS           = 16;
  localparam int unsigned DEF_UES_BITS       = 64;

  // Layout: term rows, polarity, signature, io-select, disables, two globals
  function automatic int unsigned map_len(int unsigned cells, int unsigned tpc,
                                          int unsigned sigs, int unsigned ues);
    return cells*tpc*2*sigs + cells + ues + cells + cells*tpc + 2;
  endfunction
endpackage

// File: rtl/fuse_store.sv
`timescale 1ns/1ps
module fuse_store #(
  parameter int unsigned MAP_LEN = 2194,
  localparam int unsigned CNT_W  = $clog2(MAP_LEN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               bit_i,
  output logic [MAP_LEN-1:0] map_o,
  output logic               done_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(MAP_LEN);

  logic [MAP_LEN-1:0] map_q;
  logic [CNT_W-1:0]   cnt_q;

  // New bits enter at the top; after MAP_LEN shifts the first bit sits at index 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      map_q <= {bit_i, map_q[MAP_LEN-1:1]};
      cnt_q <= (cnt_q == FULL) ? CNT_W'(1) : cnt_q + CNT_W'(1);
    end
  end

  assign map_o  = map_q;
  assign done_o = (cnt_q == FULL);

  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  a_r2_done_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && cnt_q == FULL - CNT_W'(1)) |=> done_o);
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(map_q) && $stable(cnt_q)));
  a_r10_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && done_o) |=> !done_o);
endmodule

// File: rtl/term_plane.sv
`timescale 1ns/1ps
module term_plane #(
  parameter int unsigned NTERMS = 64,
  parameter int unsigned SIGS   = 16,
  localparam int unsigned NLITS = 2 * SIGS
) (
  input  logic                     en_i,
  input  logic [SIGS-1:0]          sig_i,
  input  logic [NTERMS*NLITS-1:0]  row_i,
  input  logic [NTERMS-1:0]        kill_i,
  output logic [NTERMS-1:0]        term_o
);
  logic [NLITS-1:0] lit;

  for (genvar k = 0; k < SIGS; k++) begin : g_lit
    assign lit[2*k]   = sig_i[k];
    assign lit[2*k+1] = ~sig_i[k];
  end

  // A blown fuse (0) forces its literal slot to 1 in the AND
  for (genvar t = 0; t < NTERMS; t++) begin : g_term
    assign term_o[t] = en_i & ~kill_i[t] & (&(lit | ~row_i[t*NLITS +: NLITS]));
  end
endmodule

// File: rtl/fuse_and_array.sv
`timescale 1ns/1ps
module fuse_and_array
  import fam_pkg::*;
#(
  parameter int unsigned CELLS          = DEF_CELLS,
  parameter int unsigned TERMS_PER_CELL = DEF_TERMS_PER_CELL,
  parameter int unsigned SIGS           = DEF_SIGS,
  parameter int unsigned UES_BITS       = DEF_UES_BITS,
  localparam int unsigned NTERMS   = CELLS * TERMS_PER_CELL,
  localparam int unsigned NLITS    = 2 * SIGS,
  localparam int unsigned XOR_BASE = NTERMS * NLITS,
  localparam int unsigned UES_BASE = XOR_BASE + CELLS,
  localparam int unsigned AC1_BASE = UES_BASE + UES_BITS,
  localparam int unsigned PTD_BASE = AC1_BASE + CELLS,
  localparam int unsigned SYN_ADDR = PTD_BASE + NTERMS,
  localparam int unsigned AC0_ADDR = SYN_ADDR + 1,
  localparam int unsigned MAP_LEN  = map_len(CELLS, TERMS_PER_CELL, SIGS, UES_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                fuse_bit_i,
  input  logic [SIGS-1:0]     sig_i,
  output logic [NTERMS-1:0]   term_o,
  output logic                done_o,
  output logic [CELLS-1:0]    xor_o,
  output logic [CELLS-1:0]    ac1_o,
  output logic [UES_BITS-1:0] ues_o,
  output logic                syn_o,
  output logic                ac0_o
);
  logic [MAP_LEN-1:0] map;
  logic               done;
  logic [NTERMS-1:0]  kill;

  fuse_store #(.MAP_LEN(MAP_LEN)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .bit_i  (fuse_bit_i),
    .map_o  (map),
    .done_o (done)
  );

  assign kill = map[PTD_BASE +: NTERMS];

  term_plane #(.NTERMS(NTERMS), .SIGS(SIGS)) u_plane (
    .en_i   (done),
    .sig_i  (sig_i),
    .row_i  (map[XOR_BASE-1:0]),
    .kill_i (kill),
    .term_o (term_o)
  );

  assign done_o = done;
  assign xor_o  = map[XOR_BASE +: CELLS];
  assign ues_o  = map[UES_BASE +: UES_BITS];
  assign ac1_o  = map[AC1_BASE +: CELLS];
  assign syn_o  = map[SYN_ADDR];
  assign ac0_o  = map[AC0_ADDR];

  a_r3_idle_terms_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (term_o == '0));
  a_r6_disabled_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_o & kill) == '0);
  a_r8_ues_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(ues_o));
  a_r7_arch_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(xor_o) && $stable(ac1_o) && $stable(syn_o) && $stable(ac0_o)));
endmodule

// File: tb/fuse_and_array_test.sv
`timescale 1ns/1ps
module fuse_and_array_test;
  localparam int ML = 2194;

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, fbit = 1'b0;
  logic [15:0] sig = '0;
  logic [63:0] term, ues;
  logic [7:0]  xr, ac1;
  logic        done, syn, ac0;

  int checks = 0, fails = 0;
  logic [ML-1:0] mb;

  always #4 clk = ~clk;

  fuse_and_array uut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .fuse_bit_i(fbit), .sig_i(sig),
    .term_o(term), .done_o(done), .xor_o(xr), .ac1_o(ac1), .ues_o(ues),
    .syn_o(syn), .ac0_o(ac0)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hsh(input logic [31:0] x);
    logic [31:0] y;
    y = x * 32'd1103515245 + 32'd12345;
    return y ^ (y >> 13);
  endfunction

  function automatic void build(input int v);
    for (int t = 0; t < 64; t++) begin
      for (int k = 0; k < 16; k++) begin
        logic [31:0] m;
        m = hsh(32'(t*16 + k + v*7919)) % 8;
        mb[t*32+2*k]   = (t % 8 == 0) ? 1'b1 : (t % 8 == 1) ? 1'b0 : (m == 0);
        mb[t*32+2*k+1] = (t % 8 == 0) ? 1'b1 : (t % 8 == 1) ? 1'b0 : (m == 1);
      end
      mb[2128+t] = ((t + v) % 5 == 3);
    end
    for (int c = 0; c < 8; c++) begin
      mb[2048+c] = hsh(32'(c + 100 + v))[3];
      mb[2120+c] = hsh(32'(c + 300 + v))[5];
    end
    for (int i = 0; i < 64; i++) mb[2056+i] = hsh(32'(i + 500 + v))[4];
    mb[2192] = v[0];
    mb[2193] = ~v[0];
  endfunction

  function automatic logic [63:0] exp_t(input logic [15:0] s);
    logic [63:0] r;
    for (int t = 0; t < 64; t++) begin
      logic b;
      b = ~mb[2128+t];
      for (int k = 0; k < 16; k++) begin
        if (mb[t*32+2*k] && !s[k])   b = 1'b0;
        if (mb[t*32+2*k+1] && s[k])  b = 1'b0;
      end
      r[t] = b;
    end
    return r;
  endfunction

  task automatic load_map(input bit gaps, input bit restart);
    for (int i = 0; i < ML; i++) begin
      @(negedge clk);
      if (restart && i == 1) begin
        chk("R10 done dropped", 128'(done), 128'(0));
        chk("R10 terms silenced", 128'(term), 128'(0));
      end
      if (i == 1000) chk("R3 terms low mid-load", 128'(term), 128'(0));
      if (gaps && (i % 97 == 50)) begin
        load = 1'b0; fbit = ~mb[i];
        @(negedge clk);
      end
      if (i == ML - 1) chk("R2 not done before last", 128'(done), 128'(0));
      load = 1'b1; fbit = mb[i];
    end
    @(negedge clk);
    load = 1'b0;
    chk("R2 done after last", 128'(done), 128'(1));
  endtask

  task automatic check_map(input int stride, input string tag);
    chk("R7 xor", 128'(xr), 128'(mb[2055:2048]));
    chk("R7 ac1", 128'(ac1), 128'(mb[2127:2120]));
    chk("R7 globals", 128'({syn, ac0}), 128'({mb[2192], mb[2193]}));
    chk("R8 signature", 128'(ues), 128'(mb[2119:2056]));
    for (int s = 0; s < 65536; s += stride) begin
      sig = 16'(s);
      #1;
      chk(tag, 128'(term), 128'(exp_t(sig)));
      for (int t = 0; t < 64; t += 8)
        if (term[t] !== 1'b0) chk("R5 all-intact term", 128'(term[t]), 128'(0));
      if ((term & mb[2191:2128]) != '0) chk("R6 disabled term", 128'(term & mb[2191:2128]), 128'(0));
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #10;
    chk("R1 reset done", 128'(done), 128'(0));
    chk("R1 reset terms", 128'(term), 128'(0));
    chk("R1 reset signature", 128'(ues), 128'(0));
    chk("R1 reset arch", 128'({xr, ac1, syn, ac0}), 128'(0));
    @(negedge clk); rst_n = 1'b1;
    sig = 16'hA5C3;
    @(negedge clk);
    chk("R3 terms low before load", 128'(term), 128'(0));

    build(0);
    load_map(1'b0, 1'b0);
    check_map(1, "R4 map A sweep");

    // R9: idle clocks with toggling data change nothing
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); fbit = i[0];
    end
    sig = 16'h1234; #1;
    chk("R9 idle keeps done", 128'(done), 128'(1));
    chk("R9 idle keeps terms", 128'(term), 128'(exp_t(sig)));
    chk("R9 idle keeps signature", 128'(ues), 128'(mb[2119:2056]));
    chk("R4 term1 blank reads 1", 128'(term[1]), 128'(1));

    // R10: reload over a live map, with gaps (R9)
    build(1);
    load_map(1'b1, 1'b1);
    check_map(13, "R9 R10 map B sweep");

    build(2);
    load_map(1'b0, 1'b1);
    check_map(17, "R4 map C sweep");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule